// File: doc/BRIEF.md
# Serial Flash Single-Line Transaction Sequencer

This block runs one serial-flash transaction on a single-data-line SPI bus, driven entirely by a small register file. Software first loads the transaction fields: an opcode, a 24-bit address, a dummy-cycle count, a 32-bit outgoing word and a phase-enable word. It then writes the control register with the start bit set. The engine lowers chip select and runs each enabled phase, always in this order: opcode, address, dummy, data. It shifts MOSI out and samples MISO into a read-back register. When the transaction is over, it raises a completion flag.

A keep-select control bit leaves chip select low after the transaction. The next start then continues the same frame, so a long flash operation can be sent as a series of word-sized starts. Programmable lead and trail delays, counted in SCLK periods, space the first and last clock edges from the chip-select edges.

Register word addresses on `reg_addr`: 0 control, 1 opcode, 2 address, 3 dummy count, 4 phase enable, 5 write word, 6 read word (read only), 7 status (read only), 8 delays. Reads are combinational from `reg_addr`.

Top module: `spi_seq_engine`

## Requirements
- R1: After reset, chip select is high, SCLK is low, MOSI is low, and the status and read-word registers read zero.
- R2: The opcode phase sends the 8 bits at opcode-register bits 23:16, MSB first, only when phase-enable bit 14 is set. Enabled phases always run in the order opcode, address, dummy, data.
- R3: When phase-enable bits 11:8 equal 4'b0111, a 24-bit address phase sends address-register bits 23:0, MSB first. Any other value of that field gives no address phase.
- R4: When phase-enable bit 15 is set, the dummy phase lasts N+1 SCLK cycles, where N is dummy-register bits 3:0. MOSI is held low for the whole phase.
- R5: When phase-enable bits 3:0 equal 4'hF, a 32-bit data phase runs; any other value gives no data phase. With control bit 1 set, the write word goes out MSB first; with it clear, MOSI is low during the data phase.
- R6: With control bit 2 set, MISO is sampled on each SCLK rising edge of the data phase and shifted MSB first into the read word.
- R7: SCLK follows SPI mode 0. It idles low, its period is CLK_DIV system clocks, it stays low while chip select is high, and MOSI does not change while SCLK is high.
- R8: Status bit 0 (done) is set when a transaction completes and is cleared by an accepted start. Status bit 1 is set while chip select is low.
- R9: With control bit 8 set, chip select stays low after the transaction. A following start continues the same frame with no new chip-select edge and no lead delay.
- R10: Delay-register bits 2:0 add that many SCLK periods between the falling edge of chip select and the first SCLK rise. Bits 10:8 add that many SCLK periods between the last SCLK fall and the rising edge of chip select.
- R11: Register writes, a start included, are ignored while a transaction is in progress.
- R12: A start with no phase enabled produces no SCLK edge, pulses chip select and sets done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench counts SCLK rising edges per transaction. A design that decodes any nonzero address or data field as enabled, or that is off by one on the dummy length, shows a wrong edge count. It checks the split of bits across phases in the captured MOSI stream: an address sent LSB first, or a dummy phase that leaks data, would corrupt that stream. A two-start keep-select frame must show exactly one chip-select fall; a design that drops select between starts shows two. It also writes the opcode register and a start in mid-transfer, then reads the opcode back. It measures the extra lead and trail gaps against a zero-delay baseline, which catches delays counted in system clocks rather than SCLK periods.

// File: rtl/spi_seq_engine.sv
module spi_seq_engine #(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_cs_n,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso
);

  localparam int HALF = (CLK_DIV < 2) ? 1 : CLK_DIV / 2;
  localparam int DIVW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [DIVW-1:0] DIV_LAST = DIVW'(HALF - 1);

  localparam logic [3:0] A_CTRL = 4'd0, A_CMD = 4'd1, A_ADDR = 4'd2, A_DMY = 4'd3,
                         A_EN = 4'd4, A_WD = 4'd5, A_RD = 4'd6, A_ST = 4'd7, A_DLY = 4'd8;
  localparam logic [2:0] PH_CMD = 3'd0, PH_ADR = 3'd1, PH_DMY = 3'd2, PH_DAT = 3'd3, PH_NONE = 3'd4;

  typedef enum logic [2:0] {ST_IDLE, ST_LEAD, ST_XFER, ST_END, ST_TRAIL} st_t;

  st_t             state;
  logic [2:0]      ph;
  logic [DIVW-1:0] div_cnt;
  logic [3:0]      dly;
  logic [4:0]      bcnt;
  logic [31:0]     tx_sr, rx_sr;
  logic            cs_n_r, sclk_r, done_r;

  logic        ctl_wr, ctl_rd, ctl_keep;
  logic [7:0]  cmd_op;
  logic [23:0] adr_r;
  logic [3:0]  dmy_r;
  logic        en_dmy, en_cmd;
  logic [3:0]  adr_sel, dat_sel;
  logic [31:0] wd_r;
  logic [2:0]  lead_r, trail_r;

  logic        idle, tick, go;
  logic [3:0]  en_vec, nmask;
  logic [2:0]  first_ph, next_ph, ld_ph;
  logic [31:0] ld_tx;
  logic [4:0]  ld_cnt;

  function automatic logic [2:0] pick(input logic [3:0] v);
    if (v[0])      return PH_CMD;
    else if (v[1]) return PH_ADR;
    else if (v[2]) return PH_DMY;
    else if (v[3]) return PH_DAT;
    else           return PH_NONE;
  endfunction

  assign idle     = (state == ST_IDLE);
  assign tick     = !idle && (div_cnt == DIV_LAST);
  assign go       = reg_we && idle && (reg_addr == A_CTRL) && reg_wdata[0];
  assign en_vec   = {dat_sel == 4'hF, en_dmy, adr_sel == 4'b0111, en_cmd};
  assign nmask    = 4'b1110 << ph;
  assign first_ph = pick(en_vec);
  assign next_ph  = pick(en_vec & nmask);
  assign ld_ph    = (state == ST_LEAD) ? first_ph : next_ph;

  always_comb begin
    ld_tx  = 32'h0;
    ld_cnt = 5'd0;
    case (ld_ph)
      PH_CMD: begin ld_tx = {cmd_op, 24'h0}; ld_cnt = 5'd7;  end
      PH_ADR: begin ld_tx = {adr_r, 8'h0};   ld_cnt = 5'd23; end
      PH_DMY: begin ld_tx = 32'h0;           ld_cnt = {1'b0, dmy_r}; end
      PH_DAT: begin ld_tx = ctl_wr ? wd_r : 32'h0; ld_cnt = 5'd31; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_wr <= 1'b0; ctl_rd <= 1'b0; ctl_keep <= 1'b0;
      cmd_op <= 8'h0; adr_r <= 24'h0; dmy_r <= 4'h0;
      en_dmy <= 1'b0; en_cmd <= 1'b0; adr_sel <= 4'h0; dat_sel <= 4'h0;
      wd_r <= 32'h0; lead_r <= 3'd0; trail_r <= 3'd0;
    end else if (reg_we && idle) begin
      case (reg_addr)
        A_CTRL: begin ctl_wr <= reg_wdata[1]; ctl_rd <= reg_wdata[2]; ctl_keep <= reg_wdata[8]; end
        A_CMD:  cmd_op <= reg_wdata[23:16];
        A_ADDR: adr_r <= reg_wdata[23:0];
        A_DMY:  dmy_r <= reg_wdata[3:0];
        A_EN:   begin
                  en_dmy <= reg_wdata[15]; en_cmd <= reg_wdata[14];
                  adr_sel <= reg_wdata[11:8]; dat_sel <= reg_wdata[3:0];
                end
        A_WD:   wd_r <= reg_wdata;
        A_DLY:  begin lead_r <= reg_wdata[2:0]; trail_r <= reg_wdata[10:8]; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; ph <= PH_NONE; div_cnt <= '0; dly <= 4'd0; bcnt <= 5'd0;
      tx_sr <= 32'h0; rx_sr <= 32'h0; cs_n_r <= 1'b1; sclk_r <= 1'b0; done_r <= 1'b0;
    end else begin
      div_cnt <= (idle || tick) ? '0 : div_cnt + 1'b1;
      case (state)
        ST_IDLE: if (go) begin
          done_r <= 1'b0;
          cs_n_r <= 1'b0;
          dly    <= cs_n_r ? {lead_r, 1'b0} : 4'd0;
          state  <= ST_LEAD;
        end
        ST_LEAD: begin
          if (dly == 4'd0) begin
            div_cnt <= '0;
            if (first_ph == PH_NONE) state <= ST_END;
            else begin
              ph <= first_ph; tx_sr <= ld_tx; bcnt <= ld_cnt; state <= ST_XFER;
            end
          end else if (tick) dly <= dly - 4'd1;
        end
        ST_XFER: if (tick) begin
          if (!sclk_r) begin
            sclk_r <= 1'b1;
            if (ph == PH_DAT && ctl_rd) rx_sr <= {rx_sr[30:0], spi_miso};
          end else begin
            sclk_r <= 1'b0;
            if (bcnt == 5'd0) begin
              if (next_ph == PH_NONE) begin
                ph <= PH_NONE; state <= ST_END;
              end else begin
                ph <= next_ph; tx_sr <= ld_tx; bcnt <= ld_cnt;
              end
            end else begin
              bcnt  <= bcnt - 5'd1;
              tx_sr <= {tx_sr[30:0], 1'b0};
            end
          end
        end
        ST_END: begin
          div_cnt <= '0;
          tx_sr   <= 32'h0;
          if (ctl_keep) begin
            done_r <= 1'b1; state <= ST_IDLE;
          end else begin
            dly <= {trail_r, 1'b0}; state <= ST_TRAIL;
          end
        end
        ST_TRAIL: begin
          if (dly == 4'd0) begin
            cs_n_r <= 1'b1; done_r <= 1'b1; state <= ST_IDLE;
          end else if (tick) dly <= dly - 4'd1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign spi_cs_n = cs_n_r;
  assign spi_sclk = sclk_r;
  assign spi_mosi = (state == ST_XFER) && tx_sr[31];

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {23'h0, ctl_keep, 5'h0, ctl_rd, ctl_wr, 1'b0};
      A_CMD:   reg_rdata = {8'h0, cmd_op, 16'h0};
      A_ADDR:  reg_rdata = {8'h0, adr_r};
      A_DMY:   reg_rdata = {28'h0, dmy_r};
      A_EN:    reg_rdata = {16'h0, en_dmy, en_cmd, 2'b00, adr_sel, 4'h0, dat_sel};
      A_WD:    reg_rdata = wd_r;
      A_RD:    reg_rdata = rx_sr;
      A_ST:    reg_rdata = {30'h0, !cs_n_r, done_r};
      A_DLY:   reg_rdata = {21'h0, trail_r, 5'h0, lead_r};
      default: reg_rdata = 32'h0;
    endcase
  end

  AST_SCLK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R7
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R7
  AST_DUMMY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_XFER && ph == PH_DMY) |-> !spi_mosi); // R4
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !done_r); // R8
  AST_HELD_ONLY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !spi_cs_n) |-> ctl_keep); // R9
  AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && reg_we && reg_addr == A_CMD) |=> $stable(cmd_op)); // R11

endmodule

// File: tb/sim_spi_seq_engine.sv
module sim_spi_seq_engine;
  localparam int CLK_DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        spi_cs_n, spi_sclk, spi_mosi, spi_miso;

  int checks = 0, failures = 0;

  spi_seq_engine #(.CLK_DIV(CLK_DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  always #5 clk = ~clk;

  logic [127:0] cap;
  int edges, rise_idx, n_pre;
  logic [31:0] miso_word;

  always @(posedge spi_sclk) begin
    cap <= {cap[126:0], spi_mosi};
    edges <= edges + 1;
    rise_idx <= rise_idx + 1;
  end
  always @(negedge spi_cs_n) rise_idx <= 0;

  always_comb begin
    int k;
    k = rise_idx - n_pre;
    spi_miso = (k >= 0 && k < 32) ? miso_word[31 - k] : 1'b0;
  end

  int cyc = 0, cs_fall_cyc, cs_rise_cyc, first_rise_cyc, last_fall_cyc, last_rise_cyc;
  int cs_falls, bad_period;
  logic first_seen, prev_cs = 1'b1, prev_sclk = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (prev_cs && !spi_cs_n) begin
      cs_fall_cyc = cyc; first_seen = 1'b0; cs_falls++; last_rise_cyc = -1;
    end
    if (!prev_cs && spi_cs_n) cs_rise_cyc = cyc;
    if (!prev_sclk && spi_sclk) begin
      if (!first_seen) first_rise_cyc = cyc;
      if (first_seen && cyc - last_rise_cyc != CLK_DIV) bad_period++;
      first_seen = 1'b1;
      last_rise_cyc = cyc;
    end
    if (prev_sclk && !spi_sclk) last_fall_cyc = cyc;
    prev_cs = spi_cs_n;
    prev_sclk = spi_sclk;
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_done(string req);
    logic [31:0] s;
    bit ok = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      rd(4'd7, s);
      if (s[0]) begin ok = 1'b1; break; end
    end
    if (!ok) begin
      checks++; failures++;
      $display("FAIL %s actual=timeout expected=done", req);
    end
  endtask

  task automatic clear_mon();
    edges = 0; cs_falls = 0; bad_period = 0; cap = '0;
  endtask

  task automatic t_reset();
    logic [31:0] s;
    rd(4'd7, s);  check("R1 status", s, 0);
    rd(4'd6, s);  check("R1 read word", s, 0);
    check("R1 pins", {spi_cs_n, spi_sclk, spi_mosi}, 3'b100);
  endtask

  task automatic t_write();
    logic [31:0] s;
    clear_mon();
    wr(4'd1, 32'h00A5_0000);
    wr(4'd2, 32'h0012_3456);
    wr(4'd5, 32'hDEAD_BEEF);
    wr(4'd4, 32'h0000_470F);
    wr(4'd0, 32'h3);
    rd(4'd7, s);
    check("R8 done cleared by start", s[0], 0);
    check("R8 select flag", s[1], 1);
    wr(4'd1, 32'h0055_0000);
    wr(4'd0, 32'h3);
    wait_done("R2");
    repeat (20) @(negedge clk);
    check("R2 edge count", edges, 64);
    check("R2 opcode bits", cap[63:56], 8'hA5);
    check("R3 address bits", cap[55:32], 24'h123456);
    check("R5 write data", cap[31:0], 32'hDEADBEEF);
    check("R7 period", bad_period, 0);
    rd(4'd1, s);
    check("R11 opcode kept while busy", s, 32'h00A5_0000);
    check("R11 single frame", cs_falls, 1);
    rd(4'd7, s);
    check("R8 done and released", s[1:0], 2'b01);
  endtask

  task automatic t_read();
    logic [31:0] s;
    clear_mon();
    miso_word = 32'hC3A5_5A17;
    n_pre = 40;
    wr(4'd1, 32'h000B_0000);
    wr(4'd2, 32'h00FF_FFFF);
    wr(4'd3, 32'h7);
    wr(4'd4, 32'h0000_C70F);
    wr(4'd0, 32'h5);
    wait_done("R6");
    check("R6 edge count", edges, 72);
    rd(4'd6, s);
    check("R6 read word", s, 32'hC3A5_5A17);
    check("R2 opcode then address", cap[71:40], {8'h0B, 24'hFFFFFF});
    check("R4 dummy low", cap[39:32], 8'h00);
    check("R5 MOSI low without write", cap[31:0], 32'h0);
    n_pre = 1000;
  endtask

  task automatic t_dummy();
    clear_mon();
    wr(4'd1, 32'h00FF_0000);
    wr(4'd3, 32'h3);
    wr(4'd4, 32'h0000_C000);
    wr(4'd0, 32'h1);
    wait_done("R4");
    check("R4 dummy length", edges, 12);
    check("R4 dummy bits", cap[11:0], 12'hFF0);
  endtask

  task automatic t_fields();
    clear_mon();
    wr(4'd4, 32'h0000_4307);
    wr(4'd0, 32'h3);
    wait_done("R3");
    check("R3 R5 partial fields ignored", edges, 8);
  endtask

  task automatic t_keep();
    logic [31:0] s;
    clear_mon();
    wr(4'd8, 32'h0000_0003);
    wr(4'd4, 32'h0000_4000);
    wr(4'd1, 32'h009F_0000);
    wr(4'd0, 32'h101);
    wait_done("R9");
    rd(4'd7, s);
    check("R9 held status", s[1:0], 2'b11);
    check("R9 cs held", spi_cs_n, 0);
    wr(4'd1, 32'h003C_0000);
    wr(4'd0, 32'h1);
    wait_done("R9");
    repeat (4) @(negedge clk);
    check("R9 one frame", cs_falls, 1);
    check("R9 bits", {edges[7:0], cap[15:0]}, {8'd16, 16'h9F3C});
    check("R9 released", spi_cs_n, 1);
    wr(4'd8, 32'h0);
  endtask

  task automatic t_delay();
    int gl0, gt0;
    wr(4'd8, 32'h0);
    wr(4'd4, 32'h0000_4000);
    wr(4'd0, 32'h1);
    wait_done("R10");
    @(negedge clk);
    gl0 = first_rise_cyc - cs_fall_cyc;
    gt0 = cs_rise_cyc - last_fall_cyc;
    wr(4'd8, 32'h0000_0203);
    wr(4'd0, 32'h1);
    wait_done("R10");
    @(negedge clk);
    check("R10 lead", (first_rise_cyc - cs_fall_cyc) - gl0, 3 * CLK_DIV);
    check("R10 trail", (cs_rise_cyc - last_fall_cyc) - gt0, 2 * CLK_DIV);
    wr(4'd8, 32'h0);
  endtask

  task automatic t_empty();
    clear_mon();
    wr(4'd4, 32'h0);
    wr(4'd0, 32'h1);
    wait_done("R12");
    repeat (2) @(negedge clk);
    check("R12 no edges", edges, 0);
    check("R12 select pulsed", {cs_falls[3:0], spi_cs_n}, {4'd1, 1'b1});
  endtask

  initial begin
    n_pre = 1000; miso_word = 32'h0;
    edges = 0; rise_idx = 0; cap = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_write();
    t_read();
    t_dummy();
    t_fields();
    t_keep();
    t_delay();
    t_empty();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1500000;
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule